// File: doc/BRIEF.md
# Real-Time Clock Deferred-Write Register Interface

This block is the register file that sits between a fast synchronous host bus and the slow timebase of a real-time clock. Writes to the time, alarm, stopwatch, interrupt-enable and prescaler-enable registers are not applied when the host issues them. The block parks the write in a single staging slot and applies it on the next synchronisation tick. While the slot is full, any further write to one of these registers is thrown away. The host can tell whether a write is still waiting, and whether one has finished, by reading the status register.

The status register also collects event flags raised by the timekeeping logic next to this block. Those flags are cleared by writing ones, and such writes act on the very next clock edge. The synchronisation tick is either a one-per-second strobe or the raw oscillator strobe, depending on the prescaler-enable register. A single interrupt line combines every enabled flag.

Top module: `rtcw_top`

## Requirements
- R1: After reset every register (time, alarm, stopwatch, interrupt enable, prescaler enable, status) reads zero, nothing is pending and `irq` is low.
- R2: A write to a synced register (address 0 time, 1 alarm, 2 stopwatch, 3 interrupt enable, 4 prescaler enable) leaves the register unchanged until a synchronisation tick. The new value is visible on the cycle after the tick edge. The interrupt enable keeps bits 15:0 and the prescaler enable keeps bit 0.
- R3: Status bit 14 reads 1 from the cycle after an accepted synced write until the cycle after the tick that commits it.
- R4: A synced write that arrives while another is pending is discarded, whatever its address, and the pending write stays intact.
- R5: Status bit 15 is set on the cycle after a pending write commits. It stays set until the host writes a 1 to it at address 5.
- R6: A write to the status register (address 5) clears every bit written as 1 on the next edge. It is never staged: it neither sets nor disturbs the pending write.
- R7: `evt_set` bit n sets status bit n (0 stopwatch, 1 alarm, 2 second, 3 minute, 4 hour, 5 day rollover, 6 day alarm). A set and a clear of the same bit in one cycle leave it set.
- R8: `irq` is high exactly when some status bit 0 to 6 is set with its enable bit set, or when status bit 15 is set with enable bit 15 set.
- R9: With prescaler enable 1 the synchronisation tick is `tick_sec`. With prescaler enable 0 it is `tick_raw`, and the other strobe is ignored.
- R10: A synced write in the same cycle as a tick, with nothing pending, is staged and commits only on a later tick.
- R11: Addresses 6 and 7 read zero, and writes to them change nothing and start no pending write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_raw | input | 1 | Oscillator-rate strobe, already in the bus clock domain |
| tick_sec | input | 1 | One-per-second strobe, already in the bus clock domain |
| evt_set | input | 7 | Event flag set pulses from the timekeeping logic |
| time_q | output | 32 | Committed time value |
| alarm_q | output | 32 | Committed alarm value |
| swatch_q | output | 32 | Committed stopwatch value |
| ctrl_q | output | 16 | Committed interrupt enables |
| psen_q | output | 1 | Committed prescaler enable |
| irq | output | 1 | Combined interrupt |

## Verification
An accepted synced write shows status bit 14 one cycle after its strobe edge. Its data and status bit 15 show one cycle after the tick edge that commits it. A status clear or an event pulse shows one cycle after its edge. `irq` is combinational from status and enables, so it follows in the same cycle as they do. The bench drives all inputs just after a falling edge and holds each strobe for exactly one rising edge. It reads registers through `bus_rdata` shortly after the next falling edge, so every check lands on the first cycle its result is due. Each drop or ignore case is confirmed by reading back the register it could have touched, before any later tick.

// File: rtl/rtcw_pkg.sv
`timescale 1ns/1ps
package rtcw_pkg;
    localparam int DW       = 32;
    localparam int AW       = 3;
    localparam int CTRL_W   = 16;
    localparam int EVT_W    = 7;
    localparam int WIDE_N   = 3;
    localparam int PEND_BIT = 14;
    localparam int DONE_BIT = 15;

    typedef enum logic [AW-1:0] {
        SEL_TIME   = 3'd0,
        SEL_ALARM  = 3'd1,
        SEL_SWATCH = 3'd2,
        SEL_CTRL   = 3'd3,
        SEL_PSEN   = 3'd4,
        SEL_STAT   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] sel;
        logic [DW-1:0] data;
    } wr_req_t;

    function automatic logic is_synced(input logic [AW-1:0] sel);
        return (sel == SEL_TIME) || (sel == SEL_ALARM) || (sel == SEL_SWATCH) ||
               (sel == SEL_CTRL) || (sel == SEL_PSEN);
    endfunction
endpackage

// File: rtl/rtcw_stage.sv
`timescale 1ns/1ps
module rtcw_stage
    import rtcw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t req,
    input  logic    sync_tick,
    output logic    pending,
    output wr_req_t commit
);
    wr_req_t slot_q;
    logic    accept;

    // A slot that is already full refuses everything; a tick only retires what was already held.
    assign accept = req.vld && is_synced(req.sel) && !slot_q.vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (accept) begin
            slot_q.vld  <= 1'b1;
            slot_q.sel  <= req.sel;
            slot_q.data <= req.data;
        end else if (slot_q.vld && sync_tick) begin
            slot_q.vld <= 1'b0;
        end
    end

    assign pending = slot_q.vld;

    always_comb begin
        commit     = slot_q;
        commit.vld = slot_q.vld && sync_tick;
    end
endmodule

// File: rtl/rtcw_bank.sv
`timescale 1ns/1ps
module rtcw_bank
    import rtcw_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  wr_req_t                      commit,
    output logic [WIDE_N-1:0][DW-1:0]    wide_q,
    output logic [CTRL_W-1:0]            ctrl_q,
    output logic                         psen_q
);
    genvar g;
    generate
        for (g = 0; g < WIDE_N; g++) begin : g_wide
            localparam logic [AW-1:0] MY_SEL = AW'(g);
            always_ff @(posedge clk) begin
                if (rst)
                    wide_q[g] <= '0;
                else if (commit.vld && commit.sel == MY_SEL)
                    wide_q[g] <= commit.data;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            psen_q <= 1'b0;
        end else if (commit.vld) begin
            if (commit.sel == SEL_CTRL) ctrl_q <= commit.data[CTRL_W-1:0];
            if (commit.sel == SEL_PSEN) psen_q <= commit.data[0];
        end
    end
endmodule

// File: rtl/rtcw_irq.sv
`timescale 1ns/1ps
module rtcw_irq
    import rtcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_W-1:0]  evt_set,
    input  logic              clr_en,
    input  logic [CTRL_W-1:0] clr_mask,
    input  logic              done_set,
    input  logic              pending,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [CTRL_W-1:0] stat_rd,
    output logic              irq
);
    logic [EVT_W-1:0]  evt_q;
    logic              done_q;
    logic [CTRL_W-1:0] clr_eff;

    assign clr_eff = clr_en ? clr_mask : '0;

    // A set arriving with a clear wins, so no event is lost.
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            evt_q  <= (evt_q & ~clr_eff[EVT_W-1:0]) | evt_set;
            done_q <= (done_q & ~clr_eff[DONE_BIT]) | done_set;
        end
    end

    always_comb begin
        stat_rd              = '0;
        stat_rd[EVT_W-1:0]   = evt_q;
        stat_rd[PEND_BIT]    = pending;
        stat_rd[DONE_BIT]    = done_q;
    end

    assign irq = (|(evt_q & ctrl[EVT_W-1:0])) | (done_q & ctrl[DONE_BIT]);
endmodule

// File: rtl/rtcw_top.sv
`timescale 1ns/1ps
module rtcw_top
    import rtcw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_we,
    output logic [DW-1:0]     bus_rdata,
    input  logic              tick_raw,
    input  logic              tick_sec,
    input  logic [EVT_W-1:0]  evt_set,
    output logic [DW-1:0]     time_q,
    output logic [DW-1:0]     alarm_q,
    output logic [DW-1:0]     swatch_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              psen_q,
    output logic              irq
);
    wr_req_t                   req;
    wr_req_t                   commit;
    logic                      pending;
    logic                      sync_tick;
    logic [WIDE_N-1:0][DW-1:0] wide_q;
    logic [CTRL_W-1:0]         stat_rd;
    logic                      stat_wr;

    assign req.vld  = bus_we;
    assign req.sel  = bus_addr;
    assign req.data = bus_wdata;

    assign sync_tick = psen_q ? tick_sec : tick_raw;
    assign stat_wr   = bus_we && (bus_addr == SEL_STAT);

    rtcw_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .sync_tick (sync_tick),
        .pending   (pending),
        .commit    (commit)
    );

    rtcw_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .wide_q (wide_q),
        .ctrl_q (ctrl_q),
        .psen_q (psen_q)
    );

    rtcw_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .evt_set  (evt_set),
        .clr_en   (stat_wr),
        .clr_mask (bus_wdata[CTRL_W-1:0]),
        .done_set (commit.vld),
        .pending  (pending),
        .ctrl     (ctrl_q),
        .stat_rd  (stat_rd),
        .irq      (irq)
    );

    assign time_q   = wide_q[SEL_TIME];
    assign alarm_q  = wide_q[SEL_ALARM];
    assign swatch_q = wide_q[SEL_SWATCH];

    always_comb begin
        case (bus_addr)
            SEL_TIME:   bus_rdata = time_q;
            SEL_ALARM:  bus_rdata = alarm_q;
            SEL_SWATCH: bus_rdata = swatch_q;
            SEL_CTRL:   bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            SEL_PSEN:   bus_rdata = {{(DW-1){1'b0}}, psen_q};
            SEL_STAT:   bus_rdata = {{(DW-CTRL_W){1'b0}}, stat_rd};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtcw_chk.sv
`timescale 1ns/1ps
module rtcw_chk
    import rtcw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              tick_raw,
    input logic              tick_sec,
    input logic              sync_tick,
    input logic              pending,
    input logic [CTRL_W-1:0] stat_rd,
    input logic [DW-1:0]     time_q,
    input logic [DW-1:0]     alarm_q,
    input logic [DW-1:0]     swatch_q,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              psen_q,
    input logic              irq
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!pending && stat_rd == '0 && time_q == '0 && ctrl_q == '0 && !psen_q && !irq));

    // R2
    hold_until_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !(pending && sync_tick) |=> ($stable(time_q) && $stable(alarm_q) && $stable(swatch_q) &&
                                    $stable(ctrl_q) && $stable(psen_q)));

    // R3
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && is_synced(bus_addr) && !pending) |=> pending);

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && !sync_tick) |=> pending);

    // R5
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && sync_tick) |=> (stat_rd[DONE_BIT] && !pending));

    // R6
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == SEL_STAT && bus_wdata[DONE_BIT] && !(pending && sync_tick))
            |=> !stat_rd[DONE_BIT]);

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q == '0) |-> !irq);

    // R9
    tick_select_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && psen_q && tick_raw && !tick_sec) |=> pending);

    // R10
    same_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!pending && sync_tick && bus_we && is_synced(bus_addr)) |=> pending);
endmodule

bind rtcw_top rtcw_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tick_raw  (tick_raw),
    .tick_sec  (tick_sec),
    .sync_tick (sync_tick),
    .pending   (pending),
    .stat_rd   (stat_rd),
    .time_q    (time_q),
    .alarm_q   (alarm_q),
    .swatch_q  (swatch_q),
    .ctrl_q    (ctrl_q),
    .psen_q    (psen_q),
    .irq       (irq)
);

// File: tb/rtcw_top_bench.sv
`timescale 1ns/1ps
module rtcw_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        tick_raw = 1'b0;
    logic        tick_sec = 1'b0;
    logic [6:0]  evt_set = '0;
    logic [31:0] time_q, alarm_q, swatch_q;
    logic [15:0] ctrl_q;
    logic        psen_q;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rtcw_top u_rtcw_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .tick_raw(tick_raw), .tick_sec(tick_sec), .evt_set(evt_set),
        .time_q(time_q), .alarm_q(alarm_q), .swatch_q(swatch_q), .ctrl_q(ctrl_q),
        .psen_q(psen_q), .irq(irq)
    );

    localparam int NV = 4;
    localparam logic [2:0]  V_ADDR [NV] = '{3'd0, 3'd1, 3'd2, 3'd3};
    localparam logic [31:0] V_DATA [NV] = '{32'h0012_3456, 32'hDEAD_BEEF, 32'h0000_0100, 32'hFFFF_0041};
    localparam logic [31:0] V_EXP  [NV] = '{32'h0012_3456, 32'hDEAD_BEEF, 32'h0000_0100, 32'h0000_0041};

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Inputs change just after a falling edge; reads settle before the next rising edge.
    task automatic rd(input logic [2:0] a, input logic [31:0] mask, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #0.5;
        check(bus_rdata & mask, exp, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic raw_tick();
        tick_raw = 1'b1;
        @(negedge clk);
        tick_raw = 1'b0;
    endtask

    task automatic sec_tick();
        tick_sec = 1'b1;
        @(negedge clk);
        tick_sec = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 6; a++) rd(3'(a), 32'hFFFF_FFFF, 32'h0, "R1 reset read");
        check({31'b0, irq}, 32'h0, "R1 irq after reset");

        // Table walk: each synced register through stage, hold, commit
        for (int i = 0; i < NV; i++) begin
            wr(3'd5, 32'h8000);
            wr(V_ADDR[i], V_DATA[i]);
            rd(V_ADDR[i], 32'hFFFF_FFFF, 32'h0, "R2 value held before tick");
            rd(3'd5, 32'hC000, 32'h4000, "R3 pending after write");
            raw_tick();
            rd(V_ADDR[i], 32'hFFFF_FFFF, V_EXP[i], "R2 value after tick");
            rd(3'd5, 32'hC000, 32'h8000, "R5 done after commit");
        end
        check({31'b0, irq}, 32'h0, "R8 no enabled flag");

        // R4 writes while pending are dropped
        wr(3'd0, 32'h11);
        wr(3'd0, 32'h22);
        wr(3'd1, 32'h33);
        rd(3'd1, 32'hFFFF_FFFF, 32'hDEAD_BEEF, "R4 alarm untouched while pending");
        raw_tick();
        rd(3'd0, 32'hFFFF_FFFF, 32'h11, "R4 first write kept");
        rd(3'd1, 32'hFFFF_FFFF, 32'hDEAD_BEEF, "R4 dropped alarm write");
        rd(3'd5, 32'h4000, 32'h0, "R4 nothing left pending");

        // R6 status clear acts at once while a write is pending
        wr(3'd0, 32'h44);
        rd(3'd5, 32'hC000, 32'hC000, "R5 done held until cleared");
        wr(3'd5, 32'h8000);
        rd(3'd5, 32'hC000, 32'h4000, "R6 clear immediate, pending intact");
        raw_tick();
        rd(3'd0, 32'hFFFF_FFFF, 32'h44, "R6 pending write still commits");

        // R7/R8 events and masking (enables are 0x0041)
        wr(3'd5, 32'h8000);
        evt_set = 7'h01; @(negedge clk); evt_set = '0;
        rd(3'd5, 32'h7F, 32'h01, "R7 stopwatch flag set");
        check({31'b0, irq}, 32'h1, "R8 irq on enabled flag");
        evt_set = 7'h04; @(negedge clk); evt_set = '0;
        wr(3'd5, 32'h0001);
        rd(3'd5, 32'h7F, 32'h04, "R7 second flag set, stopwatch cleared");
        check({31'b0, irq}, 32'h0, "R8 masked flag no irq");
        evt_set = 7'h04; bus_addr = 3'd5; bus_wdata = 32'h4; bus_we = 1'b1;
        @(negedge clk);
        evt_set = '0; bus_we = 1'b0;
        rd(3'd5, 32'h7F, 32'h04, "R7 set wins over clear");
        wr(3'd5, 32'h0004);
        rd(3'd5, 32'h7F, 32'h00, "R6 flag cleared");

        // R8 done raises irq when enable bit 15 set
        wr(3'd3, 32'h8000);
        check({31'b0, irq}, 32'h0, "R8 irq low before commit");
        raw_tick();
        check({31'b0, irq}, 32'h1, "R8 irq from done");
        wr(3'd5, 32'h8000);
        check({31'b0, irq}, 32'h0, "R8 irq after done cleared");

        // R10 write in tick cycle with nothing pending
        bus_addr = 3'd0; bus_wdata = 32'h55; bus_we = 1'b1; tick_raw = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_raw = 1'b0;
        rd(3'd0, 32'hFFFF_FFFF, 32'h44, "R10 not committed in same cycle");
        rd(3'd5, 32'h4000, 32'h4000, "R10 staged");
        raw_tick();
        rd(3'd0, 32'hFFFF_FFFF, 32'h55, "R10 committed on next tick");

        // R9 tick selection
        wr(3'd4, 32'h3);
        raw_tick();
        rd(3'd4, 32'hFFFF_FFFF, 32'h1, "R2 prescaler enable bit 0");
        wr(3'd0, 32'h66);
        raw_tick();
        rd(3'd0, 32'hFFFF_FFFF, 32'h55, "R9 raw tick ignored when enabled");
        rd(3'd5, 32'h4000, 32'h4000, "R9 still pending");
        sec_tick();
        rd(3'd0, 32'hFFFF_FFFF, 32'h66, "R9 second tick commits");
        wr(3'd4, 32'h0);
        sec_tick();
        rd(3'd4, 32'hFFFF_FFFF, 32'h0, "R9 prescaler disabled");
        wr(3'd0, 32'h77);
        sec_tick();
        rd(3'd0, 32'hFFFF_FFFF, 32'h66, "R9 second tick ignored when disabled");
        raw_tick();
        rd(3'd0, 32'hFFFF_FFFF, 32'h77, "R9 raw tick commits");

        // R11 unmapped addresses
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, 32'hFFFF_FFFF, 32'h0, "R11 address 6 reads zero");
        rd(3'd7, 32'hFFFF_FFFF, 32'h0, "R11 address 7 reads zero");
        rd(3'd5, 32'h4000, 32'h0, "R11 no pending from unmapped write");
        rd(3'd0, 32'hFFFF_FFFF, 32'h77, "R11 time untouched");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule